// File: doc/BRIEF.md
# Bit-Control Port with Match Interrupt

This block implements the bit-control side of a byte-wide parallel port. A processor sends it control words and data bytes over a simple write strobe. Each pin can be set as an input or an output. The block watches a chosen subset of the input pins for a level condition and raises an interrupt when that condition becomes true. A read returns one byte that combines the live pin levels with the output register.

Configuration is stateful. A mode word that selects bit-control mode makes the next control word the pin-direction word. An interrupt control word can declare that the next control word is the monitoring mask. Other words load the interrupt vector or switch only the interrupt enable.

The monitor takes the unmasked pins and, at the chosen polarity, combines them with AND or with OR. A request is latched only on a false-to-true transition of that combined result. A latched request holds while the enable is off, and it reaches the interrupt output once the enable is set.

Top module: `bcp_port`

## Requirements
- R1: Reset (synchronous, active high) leaves the following state. Mode is 1 (input), the mask excludes every pin, and the interrupt enable and any pending request are cleared. The output register is 0, and no pin is driven (`pin_oe` = 0).
- R2: A control word with bit 0 = 0 loads bits 7:1 as the vector, and `vector` bit 0 always reads 0. Reset leaves the vector unchanged. A word that matches none of the command patterns changes nothing.
- R3: A control word whose low nibble is 1111 sets the mode from bits 7:6 (0 output, 1 input, 2 bidirectional, 3 bit-control). Bits 5:4 are ignored. In mode 0 all pins are driven.
- R4: After a mode-3 word, the next control word is stored as the pin-direction word and is not decoded as a command. In that word, 1 means input and 0 means output.
- R5: A control word whose low nibble is 0111 sets the interrupt fields. Bit 7 is the enable, bit 6 selects AND (1) or OR (0), and bit 5 selects high (1) or low (0) as the active level. When bit 4 is set, the next control word is the mask, in which a 0 bit means that pin is monitored.
- R6: An interrupt control word with bit 4 set clears a pending request in any mode.
- R7: A control word whose low nibble is 0011 sets the enable from bit 7 and leaves the AND/OR and polarity fields unchanged.
- R8: The match result is true only in mode 3. With OR it is true when any monitored pin is at the active level, and with AND when all monitored pins are. A false-to-true change latches a request, and `irq` rises one clock after the pin change when the enable is set.
- R9: A request is not made again while the match result stays true. This holds even when further monitored pins become active or the pending request was cleared.
- R10: With a mask of all ones the match result is false under both AND and OR, so no request is made.
- R11: A request latched while the enable is off is held. It appears on `irq` when the enable is later set.
- R12: A read captures, at the clock edge where `rd_en` is high, pin levels on input bits and the output register on output bits. The result is shown on `rdata` from the next cycle and is held until the next read.
- R13: A data write loads the output register, which drives `pin_out`. In mode 3, `pin_oe` is the inverse of the pin-direction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| ctrl_sel | input | 1 | 1 = write is a control word, 0 = data byte |
| wdata | input | DW | Write byte |
| rd_en | input | 1 | Read strobe |
| pin_in | input | DW | Pin levels seen by the port |
| rdata | output | DW | Merged read value |
| pin_out | output | DW | Output register value toward the pins |
| pin_oe | output | DW | Per-pin drive enable |
| irq | output | 1 | Interrupt request, active high |
| vector | output | DW | Stored interrupt vector |
| mode | output | 2 | Current port mode |

## Verification
A decoder stuck in the wrong expectation state shows up on the next control word. That word then lands as a mode, mask or direction byte, and the effect is seen on `mode` or `pin_oe` one cycle later or in missing or spurious `irq` pulses. A wrong combining function, polarity or edge flag shows up on `irq` one clock after a pin change. It appears either as a repeated request while the condition stays true or as a missing one after a genuine false-to-true transition. A wrong merge select or capture timing is visible on the first read after a direction change, because the pins are changed just after the capture edge.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [1:0] {
        PM_OUT    = 2'd0,
        PM_IN     = 2'd1,
        PM_BIDIR  = 2'd2,
        PM_BITCTL = 2'd3
    } port_mode_e;

    typedef enum logic [1:0] {
        DS_CMD,
        DS_IOSEL,
        DS_MASK
    } dec_state_e;

    typedef enum logic [2:0] {
        CK_VECTOR,
        CK_MODE,
        CK_INTCTL,
        CK_ENABLE,
        CK_NONE
    } cmd_kind_e;

    typedef struct packed {
        logic enable;
        logic use_and;
        logic act_high;
    } irq_cfg_t;

    // Sort a control word by its low bits; bit 0 low always means vector.
    function automatic cmd_kind_e classify(input logic [CMD_W-1:0] w);
        if (!w[0])                 return CK_VECTOR;
        else if (w[3:0] == 4'hF)   return CK_MODE;
        else if (w[3:0] == 4'h7)   return CK_INTCTL;
        else if (w[3:0] == 4'h3)   return CK_ENABLE;
        else                       return CK_NONE;
    endfunction

endpackage

// File: rtl/bcp_cmd_decode.sv
module bcp_cmd_decode
    import bcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output port_mode_e    mode,
    output logic [DW-1:0] iosel,
    output logic [DW-1:0] mask,
    output irq_cfg_t      cfg,
    output logic [DW-1:0] vector,
    output logic          clr_pend
);

    dec_state_e state_q;
    cmd_kind_e  kind;
    logic       cmd_phase;

    assign kind      = classify(wdata[CMD_W-1:0]);
    assign cmd_phase = wr_ctrl && (state_q == DS_CMD);
    assign clr_pend  = cmd_phase && (kind == CK_INTCTL) && wdata[4];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_CMD;
            mode    <= PM_IN;
            iosel   <= '1;
            mask    <= '1;
            cfg     <= '0;
        end else if (wr_ctrl) begin
            case (state_q)
                DS_IOSEL: begin
                    iosel   <= wdata;
                    state_q <= DS_CMD;
                end
                DS_MASK: begin
                    mask    <= wdata;
                    state_q <= DS_CMD;
                end
                default: begin
                    case (kind)
                        CK_MODE: begin
                            mode <= port_mode_e'(wdata[CMD_W-1:CMD_W-2]);
                            if (wdata[CMD_W-1:CMD_W-2] == 2'b11)
                                state_q <= DS_IOSEL;
                        end
                        CK_INTCTL: begin
                            cfg <= '{enable: wdata[7], use_and: wdata[6],
                                     act_high: wdata[5]};
                            if (wdata[4])
                                state_q <= DS_MASK;
                        end
                        CK_ENABLE: cfg.enable <= wdata[7];
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // Vector survives reset by design, so it has no reset branch.
    always_ff @(posedge clk) begin
        if (cmd_phase && kind == CK_VECTOR)
            vector <= {wdata[DW-1:1], 1'b0};
    end

    // R4
    iosel_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DS_IOSEL && wr_ctrl) |=>
            (state_q == DS_CMD && $stable(mode) && $stable(cfg)));

    // R5
    mask_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DS_MASK && wr_ctrl) |=>
            (state_q == DS_CMD && $stable(cfg) && $stable(iosel)));

    // R2
    vector_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        !(vector[0] === 1'b1));

endmodule

// File: rtl/bcp_match_irq.sv
module bcp_match_irq
    import bcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  port_mode_e    mode,
    input  logic [DW-1:0] pins,
    input  logic [DW-1:0] mask,
    input  irq_cfg_t      cfg,
    input  logic          clr_pend,
    output logic          irq
);

    logic [DW-1:0] hit;
    logic [DW-1:0] watch;
    logic          any_hit;
    logic          all_hit;
    logic          match_now;
    logic          match_q;
    logic          rise;
    logic          pend_q;

    assign hit       = cfg.act_high ? pins : ~pins;
    assign watch     = ~mask;
    assign any_hit   = |(hit & watch);
    assign all_hit   = &(hit | mask);
    assign match_now = (mode == PM_BITCTL) && (|watch) &&
                       (cfg.use_and ? all_hit : any_hit);
    assign rise      = match_now && !match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            match_q <= match_now;
            if (rise)
                pend_q <= 1'b1;
            else if (clr_pend)
                pend_q <= 1'b0;
        end
    end

    assign irq = pend_q && cfg.enable;

    // R8
    pend_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> (match_q && !$past(match_q)));

    // R10
    full_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '1 && $past(mask == '1)) |-> !match_q);

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_pend && !rise) |=> !pend_q);

endmodule

// File: rtl/bcp_data_path.sv
module bcp_data_path
    import bcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_data,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pins,
    input  port_mode_e    mode,
    input  logic [DW-1:0] iosel,
    output logic [DW-1:0] out_q,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] pin_oe
);

    logic [DW-1:0] take_pin;
    logic [DW-1:0] merged;

    always_comb begin
        case (mode)
            PM_BITCTL: begin
                take_pin = iosel;
                pin_oe   = ~iosel;
            end
            PM_OUT: begin
                take_pin = '0;
                pin_oe   = '1;
            end
            default: begin
                take_pin = '1;
                pin_oe   = '0;
            end
        endcase
    end

    for (genvar i = 0; i < DW; i++) begin : g_merge
        assign merged[i] = take_pin[i] ? pins[i] : out_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            rdata <= '0;
        end else begin
            if (wr_data)
                out_q <= wdata;
            if (rd_en)
                rdata <= merged;
        end
    end

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rdata));

    // R13
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_BITCTL) |-> ((pin_oe & iosel) == '0));

endmodule

// File: rtl/bcp_port.sv
module bcp_port
    import bcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          ctrl_sel,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe,
    output logic          irq,
    output logic [DW-1:0] vector,
    output logic [1:0]    mode
);

    port_mode_e    mode_s;
    logic [DW-1:0] iosel_s;
    logic [DW-1:0] mask_s;
    irq_cfg_t      cfg_s;
    logic          clr_s;
    logic          wr_ctrl;
    logic          wr_data;

    assign wr_ctrl = wr_en && ctrl_sel;
    assign wr_data = wr_en && !ctrl_sel;

    bcp_cmd_decode #(.DW(DW)) dec_i (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wdata    (wdata),
        .mode     (mode_s),
        .iosel    (iosel_s),
        .mask     (mask_s),
        .cfg      (cfg_s),
        .vector   (vector),
        .clr_pend (clr_s)
    );

    bcp_match_irq #(.DW(DW)) mon_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_s),
        .pins     (pin_in),
        .mask     (mask_s),
        .cfg      (cfg_s),
        .clr_pend (clr_s),
        .irq      (irq)
    );

    bcp_data_path #(.DW(DW)) dp_i (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .pins    (pin_in),
        .mode    (mode_s),
        .iosel   (iosel_s),
        .out_q   (pin_out),
        .rdata   (rdata),
        .pin_oe  (pin_oe)
    );

    assign mode = mode_s;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq && pin_oe == '0 && pin_out == '0 && mode == 2'd1));

endmodule

// File: tb/bcp_port_tb_top.sv
module bcp_port_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          ctrl_sel = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] pin_in = '0;
    logic [DW-1:0] rdata;
    logic [DW-1:0] pin_out;
    logic [DW-1:0] pin_oe;
    logic          irq;
    logic [DW-1:0] vector;
    logic [1:0]    mode;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    bcp_port #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .ctrl_sel(ctrl_sel),
        .wdata(wdata), .rd_en(rd_en), .pin_in(pin_in), .rdata(rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .vector(vector),
        .mode(mode)
    );

    // Observable selectors
    localparam int S_IRQ = 0, S_RDATA = 1, S_POUT = 2, S_OE = 3, S_VEC = 4, S_MODE = 5;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] val;
    } exp_t;

    exp_t sb_q[$];

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            S_IRQ:   return {7'd0, irq};
            S_RDATA: return rdata;
            S_POUT:  return pin_out;
            S_OE:    return pin_oe;
            S_VEC:   return vector;
            default: return {6'd0, mode};
        endcase
    endfunction

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            logic [7:0] got;
            e   = sb_q.pop_front();
            got = observe(e.sel);
            n_chk++;
            if (got !== e.val) begin
                n_err++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, got, e.val);
            end
        end
    end

    task automatic expect_v(input string r, input int s, input logic [7:0] v);
        exp_t e;
        e.req = r; e.sel = s; e.val = v;
        sb_q.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic ctrl(input logic [7:0] w);
        wr_en = 1'b1; ctrl_sel = 1'b1; wdata = w;
        tick();
    endtask

    task automatic data_wr(input logic [7:0] w);
        wr_en = 1'b1; ctrl_sel = 1'b0; wdata = w;
        tick();
    endtask

    task automatic rd();
        rd_en = 1'b1;
        tick();
    endtask

    task automatic set_pins(input logic [7:0] v);
        pin_in = v;
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        expect_v("R1", S_IRQ, 8'h00);
        expect_v("R1", S_OE, 8'h00);
        expect_v("R1", S_MODE, 8'h01);
        expect_v("R1", S_POUT, 8'h00);

        // R2 vector load, unmatched word ignored, vector kept over reset
        ctrl(8'hA4); expect_v("R2", S_VEC, 8'hA4);
        ctrl(8'h5B); expect_v("R2", S_VEC, 8'hA4); expect_v("R2", S_MODE, 8'h01);
        ctrl(8'h36); expect_v("R2", S_VEC, 8'h36);
        rst = 1'b1; tick(); rst = 1'b0;
        expect_v("R2", S_VEC, 8'h36); expect_v("R1", S_MODE, 8'h01);

        // R3 mode 0 with bits 5:4 set
        ctrl(8'h3F); expect_v("R3", S_MODE, 8'h00); expect_v("R3", S_OE, 8'hFF);
        // R13 data write
        data_wr(8'h5A); expect_v("R13", S_POUT, 8'h5A);

        // R4 mode 3, next word 0F is a direction word, not a mode word
        ctrl(8'hCF);
        ctrl(8'h0F); expect_v("R4", S_MODE, 8'h03); expect_v("R13", S_OE, 8'hF0);

        // R12 merged read, pins change after capture
        pin_in = 8'hC3; rd(); expect_v("R12", S_RDATA, 8'h53);
        set_pins(8'h00); expect_v("R12", S_RDATA, 8'h53);

        // R10 all-ones mask, OR and AND
        ctrl(8'h97); ctrl(8'hFF); expect_v("R10", S_IRQ, 8'h00);
        set_pins(8'hFF); expect_v("R10", S_IRQ, 8'h00);
        set_pins(8'h00); expect_v("R10", S_IRQ, 8'h00);
        ctrl(8'hD7); ctrl(8'hFF); expect_v("R10", S_IRQ, 8'h00);

        // R8 OR, active high, bits 1:0 monitored
        ctrl(8'hB7); ctrl(8'hFC); expect_v("R5", S_IRQ, 8'h00);
        set_pins(8'h01); expect_v("R8", S_IRQ, 8'h01);
        set_pins(8'h03); expect_v("R9", S_IRQ, 8'h01);
        ctrl(8'hB7); expect_v("R6", S_IRQ, 8'h00);
        ctrl(8'hFC); expect_v("R9", S_IRQ, 8'h00);
        set_pins(8'h02); expect_v("R9", S_IRQ, 8'h00);
        set_pins(8'h00); expect_v("R8", S_IRQ, 8'h00);
        set_pins(8'h02); expect_v("R8", S_IRQ, 8'h01);

        // R8 AND, active high
        ctrl(8'hF7); ctrl(8'hFC); expect_v("R6", S_IRQ, 8'h00);
        set_pins(8'h01); expect_v("R8", S_IRQ, 8'h00);
        set_pins(8'h03); expect_v("R8", S_IRQ, 8'h01);

        // R11 latched while disabled
        ctrl(8'h77); ctrl(8'hFC); expect_v("R6", S_IRQ, 8'h00);
        set_pins(8'h00);
        set_pins(8'h03); expect_v("R11", S_IRQ, 8'h00);
        ctrl(8'h83); expect_v("R11", S_IRQ, 8'h01);

        // R7 enable-only word keeps AND/high
        ctrl(8'hF7); ctrl(8'hFC); expect_v("R7", S_IRQ, 8'h00);
        set_pins(8'h00);
        ctrl(8'h03); ctrl(8'h83);
        set_pins(8'h01); expect_v("R7", S_IRQ, 8'h00);
        set_pins(8'h03); expect_v("R7", S_IRQ, 8'h01);

        // R6 clear in mode 0
        ctrl(8'h0F); expect_v("R6", S_IRQ, 8'h01); expect_v("R3", S_MODE, 8'h00);
        ctrl(8'h97); expect_v("R6", S_IRQ, 8'h00);
        ctrl(8'hFC); expect_v("R5", S_MODE, 8'h00);

        tick(); tick();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule